// File: doc/BRIEF.md
# Memory Operation Ordering Gate

The block watches memory instructions from the moment they are dispatched until they report completion. Every instruction carries an age tag that grows with program order, so a smaller tag is always an older instruction. Four tracked groups are kept: outstanding loads, outstanding stores, outstanding load fences and outstanding store fences. A fence is a load or store dispatched with its fence flag set. Such an instruction sits both in its plain group and in the matching fence group.

A scheduler presents a candidate instruction on the combinational query port. The block answers with the tag of the oldest instruction that holds the candidate back. When nothing holds it back, the answer is the candidate's own tag. The block also gives an issue decision that combines this answer with the candidate's operand readiness. Instructions that are neither loads nor stores pass straight through. A static relaxed-aliasing input lets loads ignore outstanding stores. Address comparison and data forwarding are left to other blocks.

Top module: `mem_order_gate`

## Requirements
- R1: After `rst_ni` is released, all four groups are empty. No dispatch stalls, and every memory query returns its own tag.
- R2: A dispatch is placed in the load group when `disp_ld_i` is set and in the store group when `disp_st_i` is set. With `disp_fence_i` also set, it goes into the load-fence and/or store-fence group as well. `disp_stall_o` is high in the same cycle when any group the dispatch targets already holds `DEPTH` entries. A stalled dispatch changes no group.
- R3: A completion on `exe_valid_i`/`exe_id_i` removes that tag from every group at the next clock edge.
- R4: A load query whose tag is younger than the oldest load fence returns that fence's tag.
- R5: A load query whose tag equals the oldest load fence returns the oldest outstanding load when that load is not the fence itself.
- R6: For stores, the same two rules apply with the oldest store fence and the oldest outstanding store. These checks follow the load-fence checks.
- R7: With `cfg_no_alias_i` high, a load that passes the fence checks returns its own tag and ignores stores.
- R8: Otherwise, a load or store query younger than the oldest outstanding store returns that store's tag.
- R9: A query that passes the store check returns its own tag in either case: when no load is outstanding, or when its tag is not younger than the oldest outstanding load.
- R10: When an older load is outstanding, a load query returns its own tag, and a store query returns the oldest outstanding load's tag.
- R11: `q_issue_o` is high exactly when `q_opnd_rdy_i` is high and the query is either not a memory operation or its returned tag equals its own. A non-memory query always returns its own tag.
- R12: The returned tag is never younger than the queried tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_no_alias_i | input | 1 | Static: loads may pass older stores |
| disp_valid_i | input | 1 | Dispatch request |
| disp_id_i | input | ID_W | Dispatch age tag |
| disp_ld_i | input | 1 | Dispatched instruction reads memory |
| disp_st_i | input | 1 | Dispatched instruction writes memory |
| disp_fence_i | input | 1 | Dispatched instruction is an ordering fence |
| disp_stall_o | output | 1 | Dispatch rejected, a target group is full |
| exe_valid_i | input | 1 | Completion report |
| exe_id_i | input | ID_W | Tag of the completed instruction |
| q_id_i | input | ID_W | Queried tag |
| q_ld_i | input | 1 | Query is a load |
| q_st_i | input | 1 | Query is a store |
| q_opnd_rdy_i | input | 1 | Query operands are ready |
| q_blocker_o | output | ID_W | Tag of the oldest blocking instruction, or the query's own tag |
| q_issue_o | output | 1 | Query may issue |

## Verification
The bench builds the block with `DEPTH` = 4 and `ID_W` = 10. The shallow groups fill after a handful of dispatches, so full-group stalls on every group, including the fence groups, occur often under random traffic. The wide tag lets each reset epoch run a few hundred strictly increasing tags without wrapping. Random epochs run with relaxed aliasing both off and on. Directed sequences place fences between older loads and stores so that every rule branch is reached.

// File: rtl/mog_pkg.sv
package mog_pkg;
  localparam int NUM_GRP = 4;
  typedef enum logic [1:0] {
    GRP_LD = 2'd0,
    GRP_ST = 2'd1,
    GRP_LF = 2'd2,
    GRP_SF = 2'd3
  } grp_e;
endpackage

// File: rtl/mog_group.sv
module mog_group #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ins_i,
  input  logic [ID_W-1:0] ins_id_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] clr_id_i,
  output logic            full_o,
  output logic            empty_o,
  output logic [ID_W-1:0] oldest_o
);
  logic [DEPTH-1:0] valid_q;
  logic [ID_W-1:0]  id_q [DEPTH];
  logic [DEPTH-1:0] slot_oh;
  logic [DEPTH-1:0] hit;

  // first free slot
  always_comb begin
    logic found;
    found   = 1'b0;
    slot_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_q[i] && !found) begin
        slot_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) hit[i] = clr_i && valid_q[i] && (id_q[i] == clr_id_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_i && slot_oh[i]) valid_q[i] <= 1'b1;
        else if (hit[i])         valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_i && slot_oh[i]) id_q[i] <= ins_id_i;
    end
  end

  // minimum search over valid entries
  always_comb begin
    logic any;
    any      = 1'b0;
    oldest_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && (!any || id_q[i] < oldest_o)) begin
        oldest_o = id_q[i];
        any      = 1'b1;
      end
    end
  end

  assign full_o  = &valid_q;
  assign empty_o = ~|valid_q;
endmodule

// File: rtl/mog_rules.sv
module mog_rules #(
  parameter int ID_W = 8
) (
  input  logic            no_alias_i,
  input  logic [ID_W-1:0] q_id_i,
  input  logic            q_ld_i,
  input  logic            q_st_i,
  input  logic            ld_empty_i,
  input  logic [ID_W-1:0] ld_old_i,
  input  logic            st_empty_i,
  input  logic [ID_W-1:0] st_old_i,
  input  logic            lf_empty_i,
  input  logic [ID_W-1:0] lf_old_i,
  input  logic            sf_empty_i,
  input  logic [ID_W-1:0] sf_old_i,
  output logic [ID_W-1:0] blk_o
);
  always_comb begin
    if (q_ld_i && !lf_empty_i && q_id_i > lf_old_i)
      blk_o = lf_old_i;
    else if (q_ld_i && !lf_empty_i && q_id_i == lf_old_i && !ld_empty_i && q_id_i != ld_old_i)
      blk_o = ld_old_i;
    else if (q_st_i && !sf_empty_i && q_id_i > sf_old_i)
      blk_o = sf_old_i;
    else if (q_st_i && !sf_empty_i && q_id_i == sf_old_i && !st_empty_i && q_id_i != st_old_i)
      blk_o = st_old_i;
    else if (no_alias_i && q_ld_i)
      blk_o = q_id_i;
    else if (!st_empty_i && q_id_i > st_old_i)
      blk_o = st_old_i;
    else if (ld_empty_i || q_id_i <= ld_old_i)
      blk_o = q_id_i;
    else if (q_ld_i)
      blk_o = q_id_i;
    else
      blk_o = ld_old_i;
  end
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
  import mog_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_no_alias_i,
  input  logic            disp_valid_i,
  input  logic [ID_W-1:0] disp_id_i,
  input  logic            disp_ld_i,
  input  logic            disp_st_i,
  input  logic            disp_fence_i,
  output logic            disp_stall_o,
  input  logic            exe_valid_i,
  input  logic [ID_W-1:0] exe_id_i,
  input  logic [ID_W-1:0] q_id_i,
  input  logic            q_ld_i,
  input  logic            q_st_i,
  input  logic            q_opnd_rdy_i,
  output logic [ID_W-1:0] q_blocker_o,
  output logic            q_issue_o
);
  logic [NUM_GRP-1:0] need;
  logic [NUM_GRP-1:0] set_full;
  logic [NUM_GRP-1:0] set_empty;
  logic [ID_W-1:0]    set_old [NUM_GRP];
  logic               disp_acc;
  logic [ID_W-1:0]    mem_blk;
  logic               is_mem;

  always_comb begin
    need         = '0;
    need[GRP_LD] = disp_ld_i;
    need[GRP_ST] = disp_st_i;
    need[GRP_LF] = disp_ld_i && disp_fence_i;
    need[GRP_SF] = disp_st_i && disp_fence_i;
  end

  assign disp_stall_o = disp_valid_i && |(need & set_full);
  assign disp_acc     = disp_valid_i && !disp_stall_o;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    mog_group #(.DEPTH(DEPTH), .ID_W(ID_W)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ins_i    (disp_acc && need[g]),
      .ins_id_i (disp_id_i),
      .clr_i    (exe_valid_i),
      .clr_id_i (exe_id_i),
      .full_o   (set_full[g]),
      .empty_o  (set_empty[g]),
      .oldest_o (set_old[g])
    );
  end

  mog_rules #(.ID_W(ID_W)) u_rules (
    .no_alias_i (cfg_no_alias_i),
    .q_id_i     (q_id_i),
    .q_ld_i     (q_ld_i),
    .q_st_i     (q_st_i),
    .ld_empty_i (set_empty[GRP_LD]),
    .ld_old_i   (set_old[GRP_LD]),
    .st_empty_i (set_empty[GRP_ST]),
    .st_old_i   (set_old[GRP_ST]),
    .lf_empty_i (set_empty[GRP_LF]),
    .lf_old_i   (set_old[GRP_LF]),
    .sf_empty_i (set_empty[GRP_SF]),
    .sf_old_i   (set_old[GRP_SF]),
    .blk_o      (mem_blk)
  );

  assign is_mem      = q_ld_i || q_st_i;
  assign q_blocker_o = is_mem ? mem_blk : q_id_i;
  assign q_issue_o   = q_opnd_rdy_i && (q_blocker_o == q_id_i);
endmodule

// File: rtl/mog_checker.sv
module mog_checker #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            disp_valid_i,
  input logic            disp_ld_i,
  input logic            disp_st_i,
  input logic            disp_fence_i,
  input logic            disp_stall_o,
  input logic [3:0]      set_full,
  input logic [3:0]      set_empty,
  input logic            disp_acc,
  input logic [ID_W-1:0] q_id_i,
  input logic            q_ld_i,
  input logic            q_st_i,
  input logic            q_opnd_rdy_i,
  input logic [ID_W-1:0] q_blocker_o,
  input logic            q_issue_o
);
  logic [3:0] tgt;
  assign tgt = {disp_st_i && disp_fence_i, disp_ld_i && disp_fence_i, disp_st_i, disp_ld_i};

  p_stall_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && (tgt & set_full) != 4'd0) |-> disp_stall_o);

  p_load_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_acc && disp_ld_i) |=> !set_empty[0]);

  p_store_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_acc && disp_st_i) |=> !set_empty[1]);

  p_blk_not_younger_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_blocker_o <= q_id_i);

  p_issue_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_issue_o |-> (q_opnd_rdy_i && q_blocker_o == q_id_i));

  p_nonmem_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_ld_i && !q_st_i) |-> (q_blocker_o == q_id_i && q_issue_o == q_opnd_rdy_i));
endmodule

bind mem_order_gate mog_checker #(.DEPTH(DEPTH), .ID_W(ID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .disp_ld_i    (disp_ld_i),
  .disp_st_i    (disp_st_i),
  .disp_fence_i (disp_fence_i),
  .disp_stall_o (disp_stall_o),
  .set_full     (set_full),
  .set_empty    (set_empty),
  .disp_acc     (disp_acc),
  .q_id_i       (q_id_i),
  .q_ld_i       (q_ld_i),
  .q_st_i       (q_st_i),
  .q_opnd_rdy_i (q_opnd_rdy_i),
  .q_blocker_o  (q_blocker_o),
  .q_issue_o    (q_issue_o)
);

// File: tb/mem_order_gate_tb.sv
module mem_order_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int ID_W       = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cfg_no_alias_i = 1'b0;
  logic            disp_valid_i = 1'b0;
  logic [ID_W-1:0] disp_id_i = '0;
  logic            disp_ld_i = 1'b0, disp_st_i = 1'b0, disp_fence_i = 1'b0;
  logic            disp_stall_o;
  logic            exe_valid_i = 1'b0;
  logic [ID_W-1:0] exe_id_i = '0;
  logic [ID_W-1:0] q_id_i = '0;
  logic            q_ld_i = 1'b0, q_st_i = 1'b0, q_opnd_rdy_i = 1'b0;
  logic [ID_W-1:0] q_blocker_o;
  logic            q_issue_o;

  mem_order_gate #(.DEPTH(DEPTH), .ID_W(ID_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;

  // reference state: group 0 loads, 1 stores, 2 load fences, 3 store fences
  bit m_v  [4][DEPTH];
  int m_id [4][DEPTH];
  string exp_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_empty(input int g);
    for (int i = 0; i < DEPTH; i++) if (m_v[g][i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_full(input int g);
    for (int i = 0; i < DEPTH; i++) if (!m_v[g][i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_old(input int g);
    int best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[g][i] && (best < 0 || m_id[g][i] < best)) best = m_id[g][i];
    return best;
  endfunction

  function automatic int ref_blk(input int id, input bit ld, input bit st, input bit na);
    int lo = m_old(0), so = m_old(1), lfo = m_old(2), sfo = m_old(3);
    if (!ld && !st) begin exp_tag = "R11"; return id; end
    if (ld && lfo >= 0) begin
      if (id > lfo) begin exp_tag = "R4"; return lfo; end
      if (id == lfo && lo >= 0 && id != lo) begin exp_tag = "R5"; return lo; end
    end
    if (st && sfo >= 0) begin
      if (id > sfo) begin exp_tag = "R6"; return sfo; end
      if (id == sfo && so >= 0 && id != so) begin exp_tag = "R6"; return so; end
    end
    if (na && ld) begin exp_tag = "R7"; return id; end
    if (so >= 0 && id > so) begin exp_tag = "R8"; return so; end
    if (lo < 0 || id <= lo) begin exp_tag = "R9"; return id; end
    exp_tag = "R10";
    return ld ? id : lo;
  endfunction

  task automatic m_insert(input int g, input int id);
    for (int i = 0; i < DEPTH; i++)
      if (!m_v[g][i]) begin m_v[g][i] = 1'b1; m_id[g][i] = id; return; end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    disp_valid_i = 1'b0; exe_valid_i = 1'b0;
    for (int g = 0; g < 4; g++) for (int i = 0; i < DEPTH; i++) m_v[g][i] = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cyc(input bit dv, input int did, input bit dl, input bit ds, input bit df,
                     input bit ev, input int eid,
                     input int qid, input bit ql, input bit qs, input bit qr,
                     output int got);
    bit exp_stall, exp_issue;
    int eb;
    @(negedge clk_i);
    disp_valid_i = dv; disp_id_i = ID_W'(did);
    disp_ld_i = dl; disp_st_i = ds; disp_fence_i = df;
    exe_valid_i = ev; exe_id_i = ID_W'(eid);
    q_id_i = ID_W'(qid); q_ld_i = ql; q_st_i = qs; q_opnd_rdy_i = qr;
    #1;
    exp_stall = dv && ((dl && m_full(0)) || (ds && m_full(1)) ||
                       (dl && df && m_full(2)) || (ds && df && m_full(3)));
    chk(disp_stall_o == exp_stall, "R2", int'(disp_stall_o), int'(exp_stall));
    eb = ref_blk(qid, ql, qs, cfg_no_alias_i);
    got = int'(q_blocker_o);
    chk(got == eb, exp_tag, got, eb);
    chk(got <= qid, "R12", got, qid);
    exp_issue = qr && (eb == qid);
    chk(q_issue_o == exp_issue, "R11", int'(q_issue_o), int'(exp_issue));
    @(posedge clk_i);
    if (ev) // R3: completion clears all groups
      for (int g = 0; g < 4; g++)
        for (int i = 0; i < DEPTH; i++) if (m_v[g][i] && m_id[g][i] == eid) m_v[g][i] = 1'b0;
    if (dv && !exp_stall) begin
      if (dl) m_insert(0, did);
      if (ds) m_insert(1, did);
      if (dl && df) m_insert(2, did);
      if (ds && df) m_insert(3, did);
    end
  endtask

  task automatic pick_pending(output bit ok, output int id);
    int g = $urandom % 4;
    int s = $urandom % DEPTH;
    ok = 1'b0; id = 0;
    for (int k = 0; k < 4 * DEPTH; k++) begin
      int gg = (g + k / DEPTH) % 4;
      int ss = (s + k) % DEPTH;
      if (m_v[gg][ss]) begin ok = 1'b1; id = m_id[gg][ss]; return; end
    end
  endtask

  task automatic random_epoch(input bit na, input int cycles);
    int next_id = 1;
    int got;
    cfg_no_alias_i = na;
    do_reset();
    for (int c = 0; c < cycles; c++) begin
      bit dv, dl, ds, df, ev, qok, ql, qs, qr;
      int eid, qid, r;
      dv = ($urandom % 3) != 0;
      r  = $urandom % 4;
      dl = (r != 1); ds = (r != 0);
      df = ($urandom % 5) == 0;
      pick_pending(ev, eid);
      if (($urandom % 3) != 0) ev = 1'b0;
      pick_pending(qok, qid);
      if (!qok || ($urandom % 2)) qid = next_id;
      r  = $urandom % 5;
      ql = (r == 0 || r == 2); qs = (r == 1 || r == 2);
      qr = ($urandom % 4) != 0;
      cyc(dv, next_id, dl, ds, df, ev, eid, qid, ql, qs, qr, got);
      if (dv) next_id++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int got;
    void'($urandom(32'h5EED_1234));

    // R1: reset state
    cfg_no_alias_i = 1'b0;
    do_reset();
    @(negedge clk_i);
    disp_valid_i = 1'b1; disp_ld_i = 1'b1; disp_st_i = 1'b1; disp_fence_i = 1'b1;
    q_id_i = 10'd7; q_ld_i = 1'b0; q_st_i = 1'b1;
    #1;
    chk(disp_stall_o == 1'b0, "R1", int'(disp_stall_o), 0);
    chk(q_blocker_o == 10'd7, "R1", int'(q_blocker_o), 7);
    disp_valid_i = 1'b0;
    do_reset();

    // directed: load 1, store 2, load fence 3
    cyc(1, 1, 1, 0, 0, 0, 0, 1, 1, 0, 1, got);
    cyc(1, 2, 0, 1, 0, 0, 0, 2, 0, 1, 1, got);
    cyc(1, 3, 1, 0, 1, 0, 0, 3, 1, 0, 1, got);
    cyc(0, 0, 0, 0, 0, 0, 0, 4, 1, 0, 1, got);   // R4 expect 3
    chk(got == 3, "R4", got, 3);
    cyc(0, 0, 0, 0, 0, 0, 0, 3, 1, 0, 1, got);   // R5 expect 1
    chk(got == 1, "R5", got, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 2, 0, 1, 1, got);   // R10 store behind load 1
    chk(got == 1, "R10", got, 1);
    cyc(1, 5, 0, 1, 1, 0, 0, 4, 0, 1, 1, got);   // R8 expect 2, store fence 5 enters
    chk(got == 2, "R8", got, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 6, 0, 1, 1, got);   // R6 younger than fence
    chk(got == 5, "R6", got, 5);
    cyc(0, 0, 0, 0, 0, 0, 0, 5, 0, 1, 1, got);   // R6 fence not oldest store
    chk(got == 2, "R6", got, 2);
    cyc(0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 1, got);   // complete fence 3
    cyc(0, 0, 0, 0, 0, 0, 0, 4, 1, 0, 1, got);   // R3: fence gone, store 2 blocks
    chk(got == 2, "R3", got, 2);
    cyc(0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0, got);
    cyc(0, 0, 0, 0, 0, 1, 5, 0, 0, 0, 0, got);
    cyc(0, 0, 0, 0, 0, 0, 0, 6, 1, 0, 1, got);   // R10 load passes older load
    chk(got == 6, "R10", got, 6);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1, got);   // R9 not younger than oldest load
    chk(got == 1, "R9", got, 1);
    // R2: fill load group then stall, stalled dispatch leaves groups unchanged
    cyc(1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 0, got);
    cyc(1, 8, 1, 0, 0, 0, 0, 0, 0, 0, 0, got);
    cyc(1, 9, 1, 0, 0, 0, 0, 0, 0, 0, 0, got);
    cyc(1, 10, 1, 1, 0, 0, 0, 10, 0, 1, 1, got);
    chk(got == 1, "R2", got, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 11, 0, 1, 1, got);  // store group untouched by stalled 10
    chk(got == 1, "R2", got, 1);

    // R7: relaxed aliasing
    cfg_no_alias_i = 1'b1;
    do_reset();
    cyc(1, 1, 0, 1, 0, 0, 0, 1, 0, 1, 1, got);
    cyc(0, 0, 0, 0, 0, 0, 0, 2, 1, 0, 1, got);
    chk(got == 2, "R7", got, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 2, 0, 1, 1, got);
    chk(got == 1, "R8", got, 1);

    for (int e = 0; e < 6; e++) random_epoch(e[0], 300);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule